// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port in which the port itself drives the shift clock. Bytes of eight bits travel least-significant bit first on one data line. The block presents that line as separate in, out and output-enable ports. A second output carries the shift clock. There are no start or stop bits. A surrounding timing generator paces all shifting with two inputs. `mc_end` is a one-clock pulse on the last clock of each machine cycle. `mc_half` is low in the first half of each machine cycle and high in the second half.

A byte write (`buf_wr`) starts a transmission. Reception starts when receive-enable is high and the receive-done flag is clear. Neither direction uses a bit counter. The transmit shift register holds a 1 above the data byte and shifts in zeros. It stops when that 1 is the only bit left above the last data bit. The receive shift register is preloaded with seven ones over a zero. It stops when the zero reaches the top bit. The transmit-done flag (`ti`) and the receive-done flag (`ri`) stay set until they are cleared through `ti_clr` and `ri_clr`.

Transmit machine: TX_IDLE goes to TX_ARM on an accepted write (the byte is loaded with its marker). TX_ARM goes to TX_WAIT on the next `mc_end`. TX_WAIT goes to TX_SEND on the following `mc_end`. TX_SEND shifts on every `mc_end` and returns to TX_IDLE, setting `ti`, on the `mc_end` where the marker reaches completion. Receive machine: RX_IDLE goes to RX_ARM when `rx_en` is 1 and `ri` is 0. RX_ARM goes to RX_WAIT on the next `mc_end`. RX_WAIT goes to RX_RECV on the following `mc_end`, loading the preload pattern. RX_RECV shifts on every `mc_end` and returns to RX_IDLE when the zero marker completes, setting `ri` and updating `rx_buf`. In this sequence, a start condition or write is counted from the first `mc_end` after the clock edge that accepts it.

Top module: `sync_shift_port`

## Requirements
- R1: A synchronous active-low reset leaves `sclk_o` = 1, `sdat_oe` = 0, `ti` = 0, `ri` = 0 and `rx_buf` = 0x00.
- R2: A transmitted frame is exactly 8 data bits with no framing bits. Data bit i appears on `sdat_o` throughout the (i+3)-th machine cycle, counting the cycle that holds the write as the first.
- R3: Sending begins only after one complete machine cycle with no activity. `sdat_oe` rises on the second `mc_end` after the write.
- R4: On the 10th `mc_end` after the write, `sdat_oe` falls and `ti` becomes 1.
- R5: A buffer write made while a transmission is under way (any state except TX_IDLE) is ignored. The byte in progress is sent unchanged and no second frame follows.
- R6: Reception starts on the clock after `rx_en` = 1 and `ri` = 0 are seen together. The shift clock becomes active on the second `mc_end` after that start.
- R7: Each received bit is the last value of `sdat_i` while `mc_half` was 0 in that machine cycle. The first bit received becomes bit 0 of `rx_buf`.
- R8: On the 10th `mc_end` after the start of reception, `ri` becomes 1, `rx_buf` takes the received byte, and the shift clock returns to idle.
- R9: `ti` and `ri` hold at 1 until `ti_clr` or `ri_clr` clears them, and a set in the same clock wins over a clear. While `ri` is 1, no reception starts and `rx_buf` keeps its value.
- R10: `sclk_o` is 1 while neither sending nor receiving. While either is active, it equals `mc_half`: low in the first half of a machine cycle and high in the second.
- R11: `sdat_oe` is 1 only while sending and 0 otherwise, including throughout reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mc_end | input | 1 | One-clock pulse on the last clock of each machine cycle |
| mc_half | input | 1 | 0 in first half of machine cycle, 1 in second half |
| buf_wr | input | 1 | Byte write strobe to the buffer register |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| ti_clr | input | 1 | Clears the transmit-done flag |
| ri_clr | input | 1 | Clears the receive-done flag |
| sdat_i | input | 1 | Data line, input side |
| sdat_o | output | 1 | Data line, output side |
| sdat_oe | output | 1 | Data line output enable |
| sclk_o | output | 1 | Shift clock |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| rx_buf | output | 8 | Last received byte |

## Verification
Several properties are checked on every cycle by the assertions. A marker is always present in each shift register while it is active. The transmit register is frozen between machine-cycle ends and when a write arrives while a frame is under way. The flags are sticky. No reception starts while `ri` is set. The shift clock follows `mc_half` whenever the data line is driven. The exact cycle counts from a write or start to the first bit and to the flags, the LSB-first ordering of sent and received bytes, and the sampling point within the machine cycle can only be shown by the bench. It does this by comparing against its cycle-by-cycle model while driving varied bytes and placing deliberately wrong data on the line in the second half of each cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARM,
        TX_WAIT,
        TX_SEND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ARM,
        RX_WAIT,
        RX_RECV
    } rx_state_t;

endpackage

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_end,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ti_clr,
    output logic              send_active,
    output logic              tx_bit,
    output logic              ti
);

    localparam int SR_W = DATA_W + 1;

    tx_state_t       state;
    tx_state_t       state_nxt;
    logic [SR_W-1:0] sreg;
    logic            at_last;
    logic            finish;

    // Completion: only the marker remains, directly above the last data bit
    assign at_last = (sreg[SR_W-1:2] == '0) && sreg[1];
    assign finish  = (state == TX_SEND) && mc_end && at_last;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE: if (buf_wr) state_nxt = TX_ARM;
            TX_ARM:  if (mc_end) state_nxt = TX_WAIT;
            TX_WAIT: if (mc_end) state_nxt = TX_SEND;
            TX_SEND: if (finish) state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            ti   <= 1'b0;
        end else begin
            if (state == TX_IDLE && buf_wr)
                sreg <= {1'b1, wr_data};
            else if (state == TX_SEND && mc_end)
                sreg <= {1'b0, sreg[SR_W-1:1]};
            if (finish)      ti <= 1'b1;
            else if (ti_clr) ti <= 1'b0;
        end
    end

    always_comb begin
        send_active = (state == TX_SEND);
        tx_bit      = send_active & sreg[0];
    end

    assert_tx_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND) |-> (sreg != '0));

    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SEND && !mc_end) |=> $stable(sreg));

    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && buf_wr && !mc_end) |=> $stable(sreg));

    assert_ti_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (ti && state == TX_IDLE));

    assert_ti_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ti && !ti_clr) |=> ti);

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_end,
    input  logic              rx_en,
    input  logic              ri_clr,
    input  logic              samp_bit,
    output logic              recv_active,
    output logic              ri,
    output logic [DATA_W-1:0] rx_buf
);

    localparam logic [DATA_W-1:0] PRELOAD = {{(DATA_W-1){1'b1}}, 1'b0};

    rx_state_t         state;
    rx_state_t         state_nxt;
    logic [DATA_W-1:0] rsreg;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] ordered;
    logic              finish;

    assign shifted = {rsreg[DATA_W-2:0], samp_bit};
    assign finish  = (state == RX_RECV) && mc_end && !rsreg[DATA_W-1];

    // First bit received ends at the top; deliver it as bit 0
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            ordered[i] = shifted[DATA_W-1-i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE: if (rx_en && !ri) state_nxt = RX_ARM;
            RX_ARM:  if (mc_end)       state_nxt = RX_WAIT;
            RX_WAIT: if (mc_end)       state_nxt = RX_RECV;
            RX_RECV: if (finish)       state_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsreg  <= '0;
            rx_buf <= '0;
            ri     <= 1'b0;
        end else begin
            if (state == RX_WAIT && mc_end)
                rsreg <= PRELOAD;
            else if (state == RX_RECV && mc_end)
                rsreg <= shifted;
            if (finish)
                rx_buf <= ordered;
            if (finish)      ri <= 1'b1;
            else if (ri_clr) ri <= 1'b0;
        end
    end

    always_comb recv_active = (state == RX_RECV);

    assert_rx_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV) |-> !(&rsreg));

    assert_ri_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (ri && state == RX_IDLE));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && ri) |=> (state == RX_IDLE));

    assert_ri_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !ri_clr) |=> ri);

    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_RECV) |=> $stable(rx_buf));

endmodule

// File: rtl/ssp_pins.sv
module ssp_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_half,
    input  logic send_active,
    input  logic recv_active,
    input  logic sdat_i,
    output logic sclk_o,
    output logic samp_bit
);

    // Keep the line value from the last clock of the low half
    always_ff @(posedge clk) begin
        if (!rst_n)        samp_bit <= 1'b0;
        else if (!mc_half) samp_bit <= sdat_i;
    end

    always_comb begin
        if (send_active || recv_active) sclk_o = mc_half;
        else                            sclk_o = 1'b1;
    end

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_end,
    input  logic              mc_half,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_en,
    input  logic              ti_clr,
    input  logic              ri_clr,
    input  logic              sdat_i,
    output logic              sdat_o,
    output logic              sdat_oe,
    output logic              sclk_o,
    output logic              ti,
    output logic              ri,
    output logic [DATA_W-1:0] rx_buf
);

    logic send_active;
    logic recv_active;
    logic samp_bit;

    ssp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_end      (mc_end),
        .buf_wr      (buf_wr),
        .wr_data     (wr_data),
        .ti_clr      (ti_clr),
        .send_active (send_active),
        .tx_bit      (sdat_o),
        .ti          (ti)
    );

    ssp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_end      (mc_end),
        .rx_en       (rx_en),
        .ri_clr      (ri_clr),
        .samp_bit    (samp_bit),
        .recv_active (recv_active),
        .ri          (ri),
        .rx_buf      (rx_buf)
    );

    ssp_pins u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_half     (mc_half),
        .send_active (send_active),
        .recv_active (recv_active),
        .sdat_i      (sdat_i),
        .sclk_o      (sclk_o),
        .samp_bit    (samp_bit)
    );

    assign sdat_oe = send_active;

    assert_oe_sclk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe |-> (sclk_o == mc_half));

endmodule

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;

    localparam int MC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_en = 1'b0;
    logic       ti_clr = 1'b0;
    logic       ri_clr = 1'b0;
    logic       sdat_i = 1'b1;
    logic       sdat_o, sdat_oe, sclk_o, ti, ri;
    logic [7:0] rx_buf;
    logic       mc_end, mc_half;
    int         ph = 0;

    always #5 clk = ~clk;

    always @(negedge clk) ph <= (ph == MC - 1) ? 0 : ph + 1;
    assign mc_end  = (ph == MC - 1);
    assign mc_half = (ph >= MC / 2);

    sync_shift_port uut (
        .clk(clk), .rst_n(rst_n), .mc_end(mc_end), .mc_half(mc_half),
        .buf_wr(buf_wr), .wr_data(wr_data), .rx_en(rx_en),
        .ti_clr(ti_clr), .ri_clr(ri_clr), .sdat_i(sdat_i),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sclk_o(sclk_o),
        .ti(ti), .ri(ri), .rx_buf(rx_buf)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: counts machine-cycle ends since each start
    int         m_tx = -1;
    int         m_rx = -1;
    logic [7:0] m_txb = '0;
    logic [7:0] m_rxb = '0;
    logic [7:0] m_buf = '0;
    logic       m_ti = 1'b0;
    logic       m_ri = 1'b0;
    logic       m_samp = 1'b0;
    logic       set_t, set_r, old_ri;
    logic [7:0] rx_pat = 8'h96;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = -1; m_rx = -1; m_ti = 0; m_ri = 0; m_buf = '0; m_samp = 0;
        end else begin
            set_t = 0; set_r = 0; old_ri = m_ri;
            if (m_tx < 0) begin
                if (buf_wr) begin m_tx = 0; m_txb = wr_data; end
            end else if (mc_end) begin
                m_tx++;
                if (m_tx == 10) begin m_tx = -1; set_t = 1; end
            end
            if (set_t) m_ti = 1; else if (ti_clr) m_ti = 0;
            if (m_rx < 0) begin
                if (rx_en && !old_ri) m_rx = 0;
            end else if (mc_end) begin
                if (m_rx >= 2) m_rxb[m_rx-2] = m_samp;
                m_rx++;
                if (m_rx == 10) begin m_rx = -1; set_r = 1; m_buf = m_rxb; end
            end
            if (set_r) m_ri = 1; else if (ri_clr) m_ri = 0;
            if (!mc_half) m_samp = sdat_i;
        end
    end

    // Far end of the line: correct bit in the low half, inverted in the high half
    always @(negedge clk) begin
        int nph;
        nph = (ph == MC - 1) ? 0 : ph + 1;
        if (m_rx >= 2 && m_rx <= 9)
            sdat_i <= (nph < MC / 2) ? rx_pat[m_rx-2] : ~rx_pat[m_rx-2];
        else
            sdat_i <= 1'b1;
    end

    // Per-clock comparison, well after the edge
    always @(posedge clk) begin
        logic exp_oe, exp_act;
        #2;
        exp_oe  = (m_tx >= 2 && m_tx <= 9);
        exp_act = exp_oe || (m_rx >= 2 && m_rx <= 9);
        chk("R4 ti", ti, m_ti);
        chk("R8 ri", ri, m_ri);
        chk("R7 rx_buf", rx_buf, m_buf);
        chk("R3 R11 sdat_oe", sdat_oe, exp_oe);
        if (exp_oe) chk("R2 sdat_o", sdat_o, m_txb[m_tx-2]);
        chk("R10 R6 sclk_o", sclk_o, exp_act ? mc_half : 1'b1);
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        buf_wr <= 1'b1; wr_data <= b;
        @(negedge clk);
        buf_wr <= 1'b0;
    endtask

    task automatic pulse_ti_clr();
        @(negedge clk); ti_clr <= 1'b1;
        @(negedge clk); ti_clr <= 1'b0;
    endtask

    task automatic pulse_ri_clr();
        @(negedge clk); ri_clr <= 1'b1;
        @(negedge clk); ri_clr <= 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sclk_o", sclk_o, 1'b1);
        chk("R1 sdat_oe", sdat_oe, 1'b0);
        chk("R1 ti", ti, 1'b0);
        chk("R1 ri", ri, 1'b0);
        chk("R1 rx_buf", rx_buf, 8'h00);

        // R2 R3 R4: frames with mixed, all-zero and all-one bytes
        write_byte(8'hA5);
        cycles(11 * MC);
        chk("R4 ti after frame", ti, 1'b1);
        pulse_ti_clr();
        chk("R9 ti cleared", ti, 1'b0);
        write_byte(8'h00);
        cycles(11 * MC);
        write_byte(8'hFF);
        cycles(3 * MC + 5);
        // R5: write while sending is ignored
        write_byte(8'h3C);
        cycles(9 * MC);
        chk("R5 no second frame", sdat_oe, 1'b0);
        chk("R4 ti set", ti, 1'b1);
        pulse_ti_clr();

        // R5 during the arming cycles
        write_byte(8'h5A);
        write_byte(8'hC3);
        cycles(12 * MC);
        pulse_ti_clr();

        // R6 R7 R8: reception
        rx_pat = 8'h96;
        @(negedge clk); rx_en <= 1'b1;
        cycles(11 * MC);
        chk("R8 ri after receive", ri, 1'b1);
        chk("R7 received byte", rx_buf, 8'h96);

        // R9: RI set blocks restart while enable stays high
        rx_pat = 8'h3E;
        cycles(4 * MC);
        chk("R9 idle clock while ri", sclk_o, 1'b1);
        chk("R9 buffer kept", rx_buf, 8'h96);

        // R6: clearing RI with enable high restarts
        pulse_ri_clr();
        cycles(11 * MC);
        chk("R6 second receive", rx_buf, 8'h3E);
        @(negedge clk); rx_en <= 1'b0;
        rx_pat = 8'h01;
        pulse_ri_clr();
        @(negedge clk); rx_en <= 1'b1;
        @(negedge clk); rx_en <= 1'b0;
        cycles(11 * MC);
        chk("R7 lsb-only byte", rx_buf, 8'h01);
        chk("R11 oe low after receive", sdat_oe, 1'b0);

        cycles(MC);
        finish_run();
    end

endmodule